// File: doc/BRIEF.md
# Memory Barrier Ordering Controller

This block sits beside the issue stage of a load/store pipeline and carries out the two data barrier operations. The first is a memory-ordering barrier. It holds back younger loads and/or stores until the selected older accesses have finished. The second is a synchronizing barrier. It imposes the same wait, and it also freezes every younger instruction until that wait ends.

Each barrier request carries three fields:
- a kind bit, which picks the memory-ordering barrier or the synchronizing barrier;
- an access-type code, which picks loads, stores or both;
- a domain code, which picks how widely shared the awaited accesses are.

A built-in tracker counts in-flight loads and stores separately for each domain. The pipeline reports every issue and every retirement of an access together with its domain. When all the counters the active barrier selects reach zero, the block pulses a done signal and drops its holds in that same cycle.

Only one barrier can be active at a time. A request that arrives while another barrier is active is held off through a ready signal.

Top module: `mbar_ctrl`

## Requirements
- R1: While reset is held low at a clock edge, the following cycle shows `hold_ld`, `hold_st`, `hold_all` and `bar_done` low, `bar_ready` high and all tracked counts at zero.
- R2: A request is accepted on a clock edge where `bar_valid` and `bar_ready` are both high. From the next cycle until the done cycle, the barrier is active and its holds are asserted.
- R3: The access-type code uses 01 for loads only, 10 for stores only, and 11 for both. Code 00 is treated as 11. An active memory-ordering barrier raises `hold_ld` only when loads are selected and `hold_st` only when stores are selected, and it waits only on the matching counters.
- R4: The domain code uses 00 for non-shareable, 01 for inner, 10 for outer and 11 for full system. A barrier waits on the counters of every domain whose code is less than or equal to its own code, and on no others.
- R5: A synchronizing barrier (`bar_sync`=1) raises `hold_all`, `hold_ld` and `hold_st` while it waits, whatever its access type. Its completion still depends only on the counters selected by R3 and R4.
- R6: A memory-ordering barrier (`bar_sync`=0) never raises `hold_all`.
- R7: While a barrier is active, `bar_done` is high in the first cycle in which all of its selected counters read zero. The pulse lasts exactly one cycle, all holds are low in that cycle, and the barrier is idle from the next cycle.
- R8: `bar_ready` is low in every cycle in which a barrier is active. A request presented during that time is accepted only after the active barrier's done cycle.
- R9: A counter rises by one for each issue and falls by one for each retirement in its type and domain. An issue and a retirement in the same cycle leave it unchanged. A retirement becomes visible in `bar_done` in the cycle after the edge that samples it.
- R10: Accesses outside the selected type or domains, including younger stores issued under a loads-only barrier, neither delay nor trigger `bar_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bar_valid | input | 1 | Barrier request present |
| bar_sync | input | 1 | 1 = synchronizing barrier, 0 = memory-ordering barrier |
| bar_acc | input | 2 | Access-type code (R3) |
| bar_dom | input | DOM_W | Domain code (R4) |
| bar_ready | output | 1 | Block can accept a barrier |
| ld_issue | input | 1 | A load was issued this cycle |
| ld_issue_dom | input | DOM_W | Domain of the issued load |
| ld_retire | input | 1 | A load completed this cycle |
| ld_retire_dom | input | DOM_W | Domain of the completed load |
| st_issue | input | 1 | A store was issued this cycle |
| st_issue_dom | input | DOM_W | Domain of the issued store |
| st_retire | input | 1 | A store completed this cycle |
| st_retire_dom | input | DOM_W | Domain of the completed store |
| hold_ld | output | 1 | Hold younger loads |
| hold_st | output | 1 | Hold younger stores |
| hold_all | output | 1 | Hold all younger instructions |
| bar_done | output | 1 | One-cycle barrier completion pulse |

## Verification
The bench targets several corner cases, each with the failure it would expose:

- **Loads-only barrier with stores in flight.** A design that also waits on, or holds, stores would keep `hold_st` high or finish late.
- **Narrower domain than the outstanding traffic.** A barrier whose domain is below that of the in-flight accesses must finish at once. A design with an inverted or widened domain test would stall.
- **Request during an active barrier.** A second barrier arrives while the first is still waiting. A design that accepts it early would overwrite the active parameters.
- **Edge cases of counting and encoding.** The bench also covers an issue and a retirement in the same cycle, code 00 for access type, and reset in the middle of a barrier. These catch counters that drift, a reserved code that ends up waiting on nothing, and holds that stay asserted across reset.

// File: rtl/mbar_pkg.sv
// Shared types and helpers for the barrier ordering controller.
// Assumes a 2-bit access-type code; the domain width is a parameter of users.
package mbar_pkg;

    typedef enum logic [1:0] {
        ACC_RSVD = 2'b00,
        ACC_LD   = 2'b01,
        ACC_ST   = 2'b10,
        ACC_ALL  = 2'b11
    } acc_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } seq_state_e;

    // Map the reserved access code onto "all accesses".
    function automatic logic [1:0] norm_acc(input logic [1:0] code);
        return (code == ACC_RSVD) ? ACC_ALL : code;
    endfunction

endpackage

// File: rtl/mbar_cnt.sv
// One up/down counter of in-flight accesses.
// Assumes the pipeline never retires more accesses than it issued and never
// exceeds 2**CNT_W-1 outstanding accesses per type and domain.
module mbar_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);

    // Track the net effect of issue and retire; both together leave it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/mbar_track.sv
// Outstanding-access tracker: one load counter and one store counter for each
// shareability domain. Issue and retire events carry the domain code of the access.
module mbar_track #(
    parameter int DOM_W = 2,
    parameter int CNT_W = 4,
    localparam int NDOM = 1 << DOM_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ld_issue,
    input  logic [DOM_W-1:0]            ld_issue_dom,
    input  logic                        ld_retire,
    input  logic [DOM_W-1:0]            ld_retire_dom,
    input  logic                        st_issue,
    input  logic [DOM_W-1:0]            st_issue_dom,
    input  logic                        st_retire,
    input  logic [DOM_W-1:0]            st_retire_dom,
    output logic [NDOM-1:0][CNT_W-1:0]  ld_cnt,
    output logic [NDOM-1:0][CNT_W-1:0]  st_cnt
);

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        logic ld_inc, ld_dec, st_inc, st_dec;

        // Decode which events belong to this domain.
        always_comb begin
            ld_inc = ld_issue  && (ld_issue_dom  == DOM_W'(d));
            ld_dec = ld_retire && (ld_retire_dom == DOM_W'(d));
            st_inc = st_issue  && (st_issue_dom  == DOM_W'(d));
            st_dec = st_retire && (st_retire_dom == DOM_W'(d));
        end

        mbar_cnt #(.CNT_W(CNT_W)) u_ld (
            .clk(clk), .rst_n(rst_n), .inc(ld_inc), .dec(ld_dec), .cnt(ld_cnt[d])
        );
        mbar_cnt #(.CNT_W(CNT_W)) u_st (
            .clk(clk), .rst_n(rst_n), .inc(st_inc), .dec(st_dec), .cnt(st_cnt[d])
        );
    end

endmodule

// File: rtl/mbar_select.sv
// Decides whether the active barrier still has older accesses to wait for.
// A domain is in scope when its code does not exceed the barrier's domain code.
// Assumes acc has already been normalised (never 00).
module mbar_select #(
    parameter int DOM_W = 2,
    parameter int CNT_W = 4,
    localparam int NDOM = 1 << DOM_W
) (
    input  logic [NDOM-1:0][CNT_W-1:0] ld_cnt,
    input  logic [NDOM-1:0][CNT_W-1:0] st_cnt,
    input  logic [1:0]                 acc,
    input  logic [DOM_W-1:0]           dom,
    output logic                       pending
);

    logic [NDOM-1:0] ld_busy;
    logic [NDOM-1:0] st_busy;

    for (genvar d = 0; d < NDOM; d++) begin : g_scope
        logic in_scope;

        // Flag domains in scope that still have accesses in flight.
        always_comb begin
            in_scope   = (dom >= DOM_W'(d));
            ld_busy[d] = in_scope && (ld_cnt[d] != '0);
            st_busy[d] = in_scope && (st_cnt[d] != '0);
        end
    end

    // Combine the per-domain flags with the access-type selection.
    always_comb begin
        pending = (acc[0] && (|ld_busy)) || (acc[1] && (|st_busy));
    end

endmodule

// File: rtl/mbar_seq.sv
// Barrier sequencer: accepts one barrier at a time, latches its parameters,
// drives the holds and the done pulse. Assumes `pending` is derived from
// the latched parameters and registered counters only.
module mbar_seq #(
    parameter int DOM_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_sync,
    input  logic [1:0]       req_acc,
    input  logic [DOM_W-1:0] req_dom,
    input  logic             pending,
    output logic             ready,
    output logic [1:0]       cur_acc,
    output logic [DOM_W-1:0] cur_dom,
    output logic             hold_ld,
    output logic             hold_st,
    output logic             hold_all,
    output logic             done
);
    import mbar_pkg::*;

    seq_state_e state;
    logic       cur_sync;
    logic       waiting;

    // Sequence state: idle -> active on accept, active -> idle on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (state == ST_IDLE && req_valid) begin
            state <= ST_ACTIVE;
        end else if (done) begin
            state <= ST_IDLE;
        end
    end

    // Capture the request fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_sync <= 1'b0;
            cur_acc  <= ACC_ALL;
            cur_dom  <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            cur_sync <= req_sync;
            cur_acc  <= norm_acc(req_acc);
            cur_dom  <= req_dom;
        end
    end

    // Derive the handshake, the done pulse and the holds.
    always_comb begin
        ready    = (state == ST_IDLE);
        done     = (state == ST_ACTIVE) && !pending;
        waiting  = (state == ST_ACTIVE) && pending;
        hold_ld  = waiting && (cur_sync || cur_acc[0]);
        hold_st  = waiting && (cur_sync || cur_acc[1]);
        hold_all = waiting && cur_sync;
    end

endmodule

// File: rtl/mbar_ctrl.sv
// Memory barrier ordering controller top. Ties the outstanding tracker, the
// wait selector and the sequencer together. Assumes the pipeline issues no
// younger access of a held type while a hold is asserted.
module mbar_ctrl #(
    parameter int DOM_W = 2,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bar_valid,
    input  logic             bar_sync,
    input  logic [1:0]       bar_acc,
    input  logic [DOM_W-1:0] bar_dom,
    output logic             bar_ready,
    input  logic             ld_issue,
    input  logic [DOM_W-1:0] ld_issue_dom,
    input  logic             ld_retire,
    input  logic [DOM_W-1:0] ld_retire_dom,
    input  logic             st_issue,
    input  logic [DOM_W-1:0] st_issue_dom,
    input  logic             st_retire,
    input  logic [DOM_W-1:0] st_retire_dom,
    output logic             hold_ld,
    output logic             hold_st,
    output logic             hold_all,
    output logic             bar_done
);
    localparam int NDOM = 1 << DOM_W;

    logic [NDOM-1:0][CNT_W-1:0] ld_cnt;
    logic [NDOM-1:0][CNT_W-1:0] st_cnt;
    logic [1:0]                 cur_acc;
    logic [DOM_W-1:0]           cur_dom;
    logic                       pending;

    mbar_track #(.DOM_W(DOM_W), .CNT_W(CNT_W)) u_track (
        .clk(clk), .rst_n(rst_n),
        .ld_issue(ld_issue), .ld_issue_dom(ld_issue_dom),
        .ld_retire(ld_retire), .ld_retire_dom(ld_retire_dom),
        .st_issue(st_issue), .st_issue_dom(st_issue_dom),
        .st_retire(st_retire), .st_retire_dom(st_retire_dom),
        .ld_cnt(ld_cnt), .st_cnt(st_cnt)
    );

    mbar_select #(.DOM_W(DOM_W), .CNT_W(CNT_W)) u_sel (
        .ld_cnt(ld_cnt), .st_cnt(st_cnt),
        .acc(cur_acc), .dom(cur_dom), .pending(pending)
    );

    mbar_seq #(.DOM_W(DOM_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(bar_valid), .req_sync(bar_sync),
        .req_acc(bar_acc), .req_dom(bar_dom),
        .pending(pending), .ready(bar_ready),
        .cur_acc(cur_acc), .cur_dom(cur_dom),
        .hold_ld(hold_ld), .hold_st(hold_st), .hold_all(hold_all),
        .done(bar_done)
    );

endmodule

// File: rtl/mbar_ctrl_chk.sv
// Property checker for mbar_ctrl, attached through bind. Observes ports only.
module mbar_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic bar_valid,
    input logic bar_ready,
    input logic hold_ld,
    input logic hold_st,
    input logic hold_all,
    input logic bar_done
);

    // R1: a reset edge leaves every output in its idle value.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!hold_ld && !hold_st && !hold_all && !bar_done && bar_ready));

    // R2: an accepted request is active on the next cycle.
    a_r2_accept_active: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_valid && bar_ready) |=> (!bar_ready && (hold_ld || hold_st || bar_done)));

    // R5 / R6: stalling everything implies stalling all memory accesses.
    a_r5_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        hold_all |-> (hold_ld && hold_st));

    // R7: done lasts exactly one cycle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bar_done |=> !bar_done);

    // R7: holds are released in the done cycle.
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        bar_done |-> (!hold_ld && !hold_st && !hold_all));

    // R8: no request is accepted while a barrier is active.
    a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ld || hold_st) |-> !bar_ready);

    // R7 / R8: the barrier goes idle right after done.
    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        bar_done |=> bar_ready);

endmodule

bind mbar_ctrl mbar_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bar_valid(bar_valid), .bar_ready(bar_ready),
    .hold_ld(hold_ld), .hold_st(hold_st), .hold_all(hold_all), .bar_done(bar_done)
);

// File: tb/mbar_ctrl_tb.sv
module mbar_ctrl_tb;
    localparam int DOM_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bv = 0, bs = 0;
    logic [1:0] ba = 0;
    logic [DOM_W-1:0] bd = 0;
    logic li = 0, lr = 0, si = 0, sr = 0;
    logic [DOM_W-1:0] lid = 0, lrd = 0, sid = 0, srd = 0;
    logic bar_ready, hold_ld, hold_st, hold_all, bar_done;

    always #2.5 clk = ~clk;

    mbar_ctrl #(.DOM_W(DOM_W), .CNT_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bar_valid(bv), .bar_sync(bs), .bar_acc(ba), .bar_dom(bd),
        .bar_ready(bar_ready),
        .ld_issue(li), .ld_issue_dom(lid), .ld_retire(lr), .ld_retire_dom(lrd),
        .st_issue(si), .st_issue_dom(sid), .st_retire(sr), .st_retire_dom(srd),
        .hold_ld(hold_ld), .hold_st(hold_st), .hold_all(hold_all), .bar_done(bar_done)
    );

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit finished = 0;

    // Behavioural reference state.
    int mld[4];
    int mst[4];
    bit mact = 0, msync = 0, m_accepted = 0;
    int macc = 3, mdom = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_pending();
        for (int d = 0; d < 4; d++) begin
            if (d <= mdom) begin
                if ((macc & 1) != 0 && mld[d] != 0) return 1;
                if ((macc & 2) != 0 && mst[d] != 0) return 1;
            end
        end
        return 0;
    endfunction

    function automatic bit e_done();  return mact && !m_pending(); endfunction
    function automatic bit e_wait();  return mact &&  m_pending(); endfunction

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        m_accepted = 0;
        if (!rst_n) begin
            for (int d = 0; d < 4; d++) begin mld[d] = 0; mst[d] = 0; end
            mact = 0; msync = 0; macc = 3; mdom = 0;
        end else begin
            if (mact && e_done()) begin
                mact = 0;
            end else if (!mact && bv) begin
                mact = 1; msync = bs; mdom = int'(bd);
                macc = (ba == 2'b00) ? 3 : int'(ba);
                m_accepted = 1;
            end
            if (li) mld[lid]++;
            if (lr) mld[lrd]--;
            if (si) mst[sid]++;
            if (sr) mst[srd]--;
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            check("R8 bar_ready", int'(bar_ready), int'(!mact));
            check("R7 bar_done", int'(bar_done), int'(e_done()));
            check("R3 hold_ld", int'(hold_ld), int'(e_wait() && (msync || (macc & 1) != 0)));
            check("R3 hold_st", int'(hold_st), int'(e_wait() && (msync || (macc & 2) != 0)));
            check("R5 R6 hold_all", int'(hold_all), int'(e_wait() && msync));
        end
    end

    task automatic request(input bit sync, input logic [1:0] acc, input logic [1:0] dom);
        @(negedge clk); bv = 1; bs = sync; ba = acc; bd = dom;
        do begin @(posedge clk); #1; end while (!m_accepted);
        @(negedge clk); bv = 0;
    endtask

    task automatic ev(input bit is_st, input bit is_ret, input logic [1:0] dom);
        @(negedge clk);
        if (!is_st && !is_ret) begin li = 1; lid = dom; end
        if (!is_st &&  is_ret) begin lr = 1; lrd = dom; end
        if ( is_st && !is_ret) begin si = 1; sid = dom; end
        if ( is_st &&  is_ret) begin sr = 1; srd = dom; end
        @(negedge clk); li = 0; lr = 0; si = 0; sr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        started = 1;
        check("R1 reset ready", int'(bar_ready), 1);
        check("R1 reset done", int'(bar_done), 0);
        rst_n = 1;
        idle(2);

        // Loads-only ordering barrier with stores in flight (R3, R10, R9).
        ev(0, 0, 2'd0); ev(0, 0, 2'd0); ev(1, 0, 2'd2);
        request(0, 2'b01, 2'd1);
        check("R2 hold after accept", int'(hold_ld), 1);
        check("R3 stores free", int'(hold_st), 0);
        check("R6 no full stall", int'(hold_all), 0);
        ev(1, 0, 2'd0);
        check("R10 younger store ignored", int'(bar_done), 0);
        ev(0, 1, 2'd0);
        check("R9 one load left", int'(bar_done), 0);
        ev(0, 1, 2'd0);
        check("R9 done after last retire", int'(bar_done), 1);
        ev(1, 1, 2'd2); ev(1, 1, 2'd0);

        // Domain scope (R4).
        ev(1, 0, 2'd2);
        request(0, 2'b10, 2'd1);
        check("R4 narrower domain done", int'(bar_done), 1);
        idle(1);
        request(0, 2'b10, 2'd3);
        check("R4 wider domain waits", int'(hold_st), 1);
        ev(1, 1, 2'd2);
        check("R4 done after store", int'(bar_done), 1);
        idle(1);

        // Synchronizing barrier and queued second request (R5, R8).
        ev(0, 0, 2'd1); ev(1, 0, 2'd3);
        request(1, 2'b01, 2'd3);
        check("R5 full stall", int'(hold_all), 1);
        check("R5 store hold", int'(hold_st), 1);
        fork
            request(0, 2'b11, 2'd3);
            begin
                @(negedge clk); @(negedge clk);
                check("R8 busy", int'(bar_ready), 0);
                ev(0, 1, 2'd1);
            end
        join
        check("R8 queued barrier waits store", int'(hold_st), 1);
        ev(1, 1, 2'd3);
        check("R7 queued done", int'(bar_done), 1);
        idle(1);

        // Reserved access code means all (R3).
        ev(0, 0, 2'd0);
        request(0, 2'b00, 2'd0);
        check("R3 reserved holds loads", int'(hold_ld), 1);
        check("R3 reserved holds stores", int'(hold_st), 1);
        ev(0, 1, 2'd0);
        idle(1);

        // Simultaneous issue and retire (R9).
        ev(0, 0, 2'd2);
        request(0, 2'b11, 2'd3);
        @(negedge clk); li = 1; lid = 2'd2; lr = 1; lrd = 2'd2;
        @(negedge clk); li = 0; lr = 0;
        check("R9 net zero keeps wait", int'(bar_done), 0);
        ev(0, 1, 2'd2);
        check("R9 done", int'(bar_done), 1);
        idle(1);

        // Reset mid-barrier (R1).
        ev(1, 0, 2'd1);
        request(1, 2'b11, 2'd3);
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        check("R1 holds cleared", int'(hold_all), 0);
        check("R1 ready", int'(bar_ready), 1);
        rst_n = 1;
        request(0, 2'b11, 2'd3);
        check("R1 counters cleared", int'(bar_done), 1);
        idle(3);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule